// File: doc/BRIEF.md
# Crystal Oscillator Startup Delay Timer

This block decides when a crystal oscillator's output is valid. It runs entirely on the slow clock. Software writes an enable bit and an 8-bit startup count through a single-cycle write strobe. An enabling write does four things: it puts the oscillator pads into crystal mode, drops the ready status, loads a down-counter with the count and restarts a prescaler. The prescaler divides the slow clock by eight, and the counter steps down once per prescaler tick.

When the countdown runs out, a sticky ready status rises. It stays high until the next write. A write with the enable bit low turns the oscillator off: the pads return to bypass mode and the ready status drops at once. An interrupt request follows the ready status whenever the interrupt mask bit is set.

At a 32 kHz slow clock, the largest count gives a delay of roughly 62 ms. The pads are in bypass mode and ready is low out of reset, so the oscillator is neither running nor usable as the main clock source. The block has no streaming data path. All of its pins are plain control and status levels, so no valid/ready handshake or back-pressure applies.

Top module: `osc_startup_timer`

## Requirements
- R1: While rst_n is low and after its release with no write, pad_osc_mode, xtal_ready and irq are all 0.
- R2: A cycle with wr_strobe=1 and wr_enable=1 makes pad_osc_mode 1 and xtal_ready 0 from the next clock edge.
- R3: After an enabling write with startup count N in 1..255, xtal_ready rises at exactly the 8*N-th clock edge after the write edge and is 0 before it. The prescaler restarts on the write, and the counter steps down once every 8 clocks.
- R4: A startup count of 0 makes xtal_ready rise at the 8th clock edge after the enabling write.
- R5: Once set, xtal_ready stays 1 with no further writes. The counter stays at zero and does not wrap to restart a countdown.
- R6: A cycle with wr_strobe=1 and wr_enable=0 makes pad_osc_mode 0 and xtal_ready 0 from the next clock edge, and they stay 0 with no further writes.
- R7: irq is 1 exactly when xtal_ready and irq_mask are both 1. It follows irq_mask with no clock delay.
- R8: An enabling write issued while a countdown is in progress, or after ready has been set, clears xtal_ready and restarts the full interval from the new write edge, timed as in R3/R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; all state runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | One-cycle register write strobe |
| wr_enable | input | 1 | Enable bit carried by the write |
| wr_count | input | 8 | Startup count carried by the write |
| irq_mask | input | 1 | Interrupt mask for the ready status |
| pad_osc_mode | output | 1 | 1 = pads in crystal mode, 0 = bypass |
| xtal_ready | output | 1 | Sticky oscillator-valid status |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default build: an 8-bit count and a divide-by-eight prescaler (DIV_LOG2=3). It sweeps counts 0 through 40 and 240 through 255, checking every edge where ready may first rise. This covers the zero case, the smallest intervals and the top of the count range, where a narrowed or wrapped counter would show. Directed sequences then cover disabling in mid-count, re-enabling over a running or finished countdown, hold after ready, and the mask gating of the interrupt.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;
  typedef enum logic {
    PAD_BYPASS = 1'b0,
    PAD_XTAL   = 1'b1
  } pad_mode_e;

  typedef struct packed {
    logic load;
    logic stop;
  } wr_cmd_t;
endpackage

// File: rtl/osc_prescaler.sv
module osc_prescaler #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam logic [DIV_LOG2-1:0] LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (run)     phase <= phase + 1'b1;
  end

  assign tick = run && (phase == LAST);

  AST_TICK_NOT_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick) else $error("tick right after restart"); // R3
endmodule

// File: rtl/osc_downcount.sv
module osc_downcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain;
  logic             at_end;

  assign at_end = (remain <= ONE);
  assign expire = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     remain <= '0;
    else if (load)  remain <= load_val;
    else if (clear) remain <= '0;
    else if (tick)  remain <= at_end ? '0 : remain - ONE;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && remain == '0) |=> remain == '0) else $error("counter wrapped"); // R5
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain == $past(load_val)) else $error("load value lost"); // R2
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
  import osc_startup_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DIV_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_strobe,
  input  logic             wr_enable,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             irq_mask,
  output logic             pad_osc_mode,
  output logic             xtal_ready,
  output logic             irq
);
  wr_cmd_t   cmd;
  pad_mode_e pad_q;
  logic      ready_q;
  logic      running;
  logic      tick;
  logic      expire;

  assign cmd.load = wr_strobe && wr_enable;
  assign cmd.stop = wr_strobe && !wr_enable;
  assign running  = (pad_q == PAD_XTAL) && !ready_q;

  osc_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_strobe),
    .run     (running),
    .tick    (tick)
  );

  osc_downcount #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd.load),
    .clear    (cmd.stop),
    .load_val (wr_count),
    .tick     (tick),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q   <= PAD_BYPASS;
      ready_q <= 1'b0;
    end else if (wr_strobe) begin
      pad_q   <= wr_enable ? PAD_XTAL : PAD_BYPASS;
      ready_q <= 1'b0;
    end else if (expire) begin
      ready_q <= 1'b1;
    end
  end

  assign pad_osc_mode = (pad_q == PAD_XTAL);
  assign xtal_ready   = ready_q;
  assign irq          = ready_q && irq_mask;

  AST_READY_NEEDS_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_ready |-> pad_osc_mode) else $error("ready without crystal mode"); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.stop |=> (!xtal_ready && !pad_osc_mode)) else $error("disable ignored"); // R6
  AST_ENABLE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.load |=> (!xtal_ready && pad_osc_mode)) else $error("enable ignored"); // R2
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (xtal_ready && !wr_strobe) |=> xtal_ready) else $error("ready dropped"); // R5
endmodule

// File: tb/test_osc_startup_timer.sv
module test_osc_startup_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_strobe = 1'b0;
  logic       wr_enable = 1'b0;
  logic [7:0] wr_count = '0;
  logic       irq_mask = 1'b0;
  logic       pad_osc_mode, xtal_ready, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  osc_startup_timer #(.CNT_W(8), .DIV_LOG2(3)) i_osc_startup_timer (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_enable(wr_enable),
    .wr_count(wr_count), .irq_mask(irq_mask),
    .pad_osc_mode(pad_osc_mode), .xtal_ready(xtal_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {pad,ready,irq} actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // Issue a write; returns positioned between the write edge and the next edge.
  task automatic do_write(input logic en, input logic [7:0] n);
    @(negedge clk);
    wr_strobe = 1'b1; wr_enable = en; wr_count = n;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic run_interval(input string req, input int n);
    int t;
    t = 8 * ((n == 0) ? 1 : n);
    do_write(1'b1, n[7:0]);
    check("R2", {pad_osc_mode, xtal_ready, irq}, 3'b100);
    repeat (t - 1) @(negedge clk);
    check(req, {pad_osc_mode, xtal_ready, irq}, 3'b100);
    @(negedge clk);
    check(req, {pad_osc_mode, xtal_ready, irq}, {2'b11, irq_mask});
  endtask

  initial begin
    irq_mask = 1'b1;
    #3;
    check("R1", {pad_osc_mode, xtal_ready, irq}, 3'b000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1", {pad_osc_mode, xtal_ready, irq}, 3'b000);

    // R4 zero count, R3 sweep low and high ends
    run_interval("R4", 0);
    for (int n = 1; n <= 40; n++) run_interval("R3", n);
    irq_mask = 1'b0;
    for (int n = 240; n <= 255; n++) run_interval("R3", n);

    // R5 hold after ready, no wrap
    repeat (300) @(negedge clk);
    check("R5", {pad_osc_mode, xtal_ready, irq}, 3'b110);

    // R7 mask gating with no clock delay
    irq_mask = 1'b1; #1;
    check("R7", {pad_osc_mode, xtal_ready, irq}, 3'b111);
    irq_mask = 1'b0; #1;
    check("R7", {pad_osc_mode, xtal_ready, irq}, 3'b110);
    irq_mask = 1'b1;

    // R8 re-enable after ready
    run_interval("R8", 3);
    // R8 re-enable in mid-count: start 10, re-write 2 after 20 clocks
    do_write(1'b1, 8'd10);
    repeat (20) @(negedge clk);
    run_interval("R8", 2);

    // R6 disable after ready, and in mid-count
    do_write(1'b0, 8'd5);
    check("R6", {pad_osc_mode, xtal_ready, irq}, 3'b000);
    repeat (100) @(negedge clk);
    check("R6", {pad_osc_mode, xtal_ready, irq}, 3'b000);
    do_write(1'b1, 8'd4);
    repeat (10) @(negedge clk);
    do_write(1'b0, 8'd0);
    repeat (64) @(negedge clk);
    check("R6", {pad_osc_mode, xtal_ready, irq}, 3'b000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule